// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router with Edge Peripheral Delivery

This block is one switching node of a two-dimensional mesh. It has five flit channels (east, west, north, south and local), each with an input buffer, and forwards 32-bit flits between them. Packets are switched in wormhole fashion. The header flit claims an output port, and that port stays with the packet until its final payload flit has left. The path is chosen by dimension-ordered XY routing. When several inputs want the same output, a rotating-priority arbiter picks the winner. Flow control on every link uses credits: one credit per buffer slot.

A router on the edge of the mesh has one side with no neighbour. That port can be given to a peripheral. A flag bit in the header's target field marks a packet as peripheral traffic. When such a packet reaches its target router, it leaves through the configured edge port instead of the local port. On routers built without a peripheral, the flag is ignored. The router's own coordinates, the peripheral port and the buffer depths are parameters.

Top module: `mesh_router_bp`

## Requirements
- R1: While reset is held and right after it is released with no input traffic, no output channel is valid and no credit is returned on any input.
- R2: Header layout: bits [3:0] are the target Y, bits [7:4] the target X, bit 8 the peripheral flag. When the target X differs from the router's X, the packet leaves on east (port 0) if the target X is larger and on west (port 1) if it is smaller, whatever its Y.
- R3: When the target X matches, the packet leaves on north (port 2) for a larger target Y and on south (port 3) for a smaller one.
- R4: A packet whose target equals the router's coordinates and whose flag is 0 leaves on the local port (port 4).
- R5: A packet with the flag set leaves on the configured peripheral port once it reaches its target router. Before that, the flag has no effect on the XY choice.
- R6: Bits [15:0] of the second flit give the payload length in flits. All flits of one packet leave on one output, unchanged, in order and without flits of another packet between them.
- R7: Inputs that compete for a busy output are served in rotating order starting after the last winner, so two persistent requesters alternate packet by packet.
- R8: An output sends only while it holds credit. It starts with the downstream depth of credits (8), spends one per flit, regains one per returned credit, and never holds more than the downstream depth.
- R9: Each input returns exactly one credit pulse for every flit it forwards. An input that respects its credits never has a flit dropped.
- R10: A packet with payload length 0 consists of header and length flits only, and it releases its output right after the length flit.
- R11: In a router built without a peripheral port, a flagged packet that reaches its target router is delivered to the local port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 5 | Per-input flit strobe, bit index = port number |
| in_flit | input | 160 | Input flits, port p at bits [32p+31:32p] |
| in_credit | output | 5 | Per-input credit pulse sent upstream when a buffered flit leaves |
| out_valid | output | 5 | Per-output flit strobe |
| out_flit | output | 160 | Output flits, port p at bits [32p+31:32p] |
| out_credit | input | 5 | Per-output credit pulse returned by the downstream buffer |

## Verification
The checks assume an upstream sender never sends a flit into a full buffer, unless a credit for that input is being returned in the same cycle. They also assume a downstream receiver returns at most one credit for each flit it accepted, so the credit count never exceeds the downstream depth. The bench keeps its own credit count per input. It starts each count at the buffer depth, spends one per flit and adds one per observed credit pulse, and it sends only when the count is positive. On each output it returns credits only for flits it has received, one per cycle. When an output is deliberately stalled, those credits are held back and released later.

// File: rtl/router_pkg.sv
package router_pkg;

    localparam int NPORT = 5;
    localparam int PW    = 3;

    typedef enum logic [PW-1:0] {
        P_EAST  = 3'd0,
        P_WEST  = 3'd1,
        P_NORTH = 3'd2,
        P_SOUTH = 3'd3,
        P_LOCAL = 3'd4
    } port_e;

    // packet progress of one input
    localparam logic [1:0] PH_HEAD = 2'd0;
    localparam logic [1:0] PH_SIZE = 2'd1;
    localparam logic [1:0] PH_BODY = 2'd2;

endpackage

// File: rtl/router_in_fifo.sv
module router_in_fifo #(
    parameter  int W     = 32,
    parameter  int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [W-1:0]  mem_q [DEPTH];
    logic          do_push, do_pop;

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign dout  = mem_q[st_q.rd];

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && !empty;
        // a slot freed in this cycle may be refilled in the same cycle
        do_push = push && (!full || do_pop);
        if (do_push) begin
            st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[st_q.wr] <= din;
        end
    end

endmodule

// File: rtl/router_rr_arb.sv
module router_rr_arb #(
    parameter  int N  = 5,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          grant_any,
    output logic [IW-1:0] grant_idx
);

    always_comb begin
        grant_any = 1'b0;
        grant_idx = '0;
        for (int k = 0; k < N; k++) begin
            logic [IW-1:0] idx;
            idx = IW'((int'(ptr) + k) % N);
            if (!grant_any && req[idx]) begin
                grant_any = 1'b1;
                grant_idx = idx;
            end
        end
    end

endmodule

// File: rtl/router_xy_route.sv
module router_xy_route
    import router_pkg::*;
#(
    parameter  int X_W         = 4,
    parameter  int Y_W         = 4,
    parameter  int MY_X        = 0,
    parameter  int MY_Y        = 0,
    parameter  bit PERIPH_EN   = 1'b1,
    parameter  int PERIPH_PORT = 3,
    localparam int TW          = X_W + Y_W + 1
) (
    input  logic [TW-1:0] tgt,
    output logic [PW-1:0] port
);

    logic [X_W-1:0] tx;
    logic [Y_W-1:0] ty;
    logic           flag;
    logic [PW-1:0]  term_port;

    assign tx   = tgt[X_W+Y_W-1:Y_W];
    assign ty   = tgt[Y_W-1:0];
    assign flag = tgt[X_W+Y_W];

    if (PERIPH_EN) begin : g_periph
        assign term_port = flag ? PW'(PERIPH_PORT) : PW'(P_LOCAL);
    end else begin : g_no_periph
        logic unused_flag;
        assign unused_flag = flag;
        assign term_port   = PW'(P_LOCAL);
    end

    always_comb begin
        if (tx > X_W'(MY_X)) begin
            port = PW'(P_EAST);
        end else if (tx < X_W'(MY_X)) begin
            port = PW'(P_WEST);
        end else if (ty > Y_W'(MY_Y)) begin
            port = PW'(P_NORTH);
        end else if (ty < Y_W'(MY_Y)) begin
            port = PW'(P_SOUTH);
        end else begin
            port = term_port;
        end
    end

endmodule

// File: rtl/mesh_router_bp.sv
module mesh_router_bp
    import router_pkg::*;
#(
    parameter  int FLIT_W      = 32,
    parameter  int BUF_DEPTH   = 8,
    parameter  int DOWN_DEPTH  = 8,
    parameter  int LEN_W       = 16,
    parameter  int X_W         = 4,
    parameter  int Y_W         = 4,
    parameter  int MY_X        = 0,
    parameter  int MY_Y        = 0,
    parameter  bit PERIPH_EN   = 1'b1,
    parameter  int PERIPH_PORT = 3,
    localparam int NP          = NPORT,
    localparam int CW          = $clog2(DOWN_DEPTH + 1),
    localparam int TW          = X_W + Y_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NP-1:0]        in_valid,
    input  logic [NP*FLIT_W-1:0] in_flit,
    output logic [NP-1:0]        in_credit,
    output logic [NP-1:0]        out_valid,
    output logic [NP*FLIT_W-1:0] out_flit,
    input  logic [NP-1:0]        out_credit
);

    typedef struct packed {
        logic [NP-1:0][1:0]       phase;   // per input
        logic [NP-1:0][LEN_W-1:0] remain;  // per input
        logic [NP-1:0][PW-1:0]    dest;    // per input
        logic [NP-1:0]            hold;    // per input: owns an output
        logic [NP-1:0]            busy;    // per output: reserved
        logic [NP-1:0][PW-1:0]    rr;      // per output: rotating start
        logic [NP-1:0][CW-1:0]    cred;    // per output: downstream space
    } rt_st_t;

    rt_st_t              st_d, st_q;

    logic [FLIT_W-1:0]   head       [NP];
    logic [PW-1:0]       route_port [NP];
    logic [NP-1:0]       req_m      [NP];
    logic [PW-1:0]       gnt_idx    [NP];
    logic [NP-1:0]       gnt_any;
    logic [NP-1:0]       fifo_empty;
    logic [NP-1:0]       fifo_full;
    logic [NP-1:0]       fwd;
    logic [NP*CW-1:0]    cred_flat;

    assign cred_flat = st_q.cred;
    assign in_credit = fwd;

    // one buffer and one route decoder per input
    for (genvar gi = 0; gi < NP; gi++) begin : g_in
        router_in_fifo #(
            .W     (FLIT_W),
            .DEPTH (BUF_DEPTH)
        ) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (in_valid[gi]),
            .din   (in_flit[gi*FLIT_W +: FLIT_W]),
            .pop   (fwd[gi]),
            .dout  (head[gi]),
            .empty (fifo_empty[gi]),
            .full  (fifo_full[gi])
        );

        router_xy_route #(
            .X_W         (X_W),
            .Y_W         (Y_W),
            .MY_X        (MY_X),
            .MY_Y        (MY_Y),
            .PERIPH_EN   (PERIPH_EN),
            .PERIPH_PORT (PERIPH_PORT)
        ) u_route (
            .tgt  (head[gi][TW-1:0]),
            .port (route_port[gi])
        );
    end

    // one arbiter per output
    for (genvar go = 0; go < NP; go++) begin : g_out
        router_rr_arb #(
            .N (NP)
        ) u_arb (
            .req       (req_m[go]),
            .ptr       (st_q.rr[go]),
            .grant_any (gnt_any[go]),
            .grant_idx (gnt_idx[go])
        );
    end

    // requests from waiting headers
    always_comb begin
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                req_m[o][i] = !st_q.hold[i] && !fifo_empty[i] &&
                              (st_q.phase[i] == PH_HEAD) &&
                              (route_port[i] == PW'(o));
            end
        end
    end

    always_comb begin
        logic last;
        st_d      = st_q;
        fwd       = '0;
        out_valid = '0;
        out_flit  = '0;
        last      = 1'b0;

        // reserve free outputs
        for (int o = 0; o < NP; o++) begin
            if (!st_q.busy[o] && gnt_any[o]) begin
                st_d.busy[o]           = 1'b1;
                st_d.rr[o]             = (gnt_idx[o] == PW'(NP - 1)) ? '0
                                                                     : gnt_idx[o] + 1'b1;
                st_d.hold[gnt_idx[o]]  = 1'b1;
                st_d.dest[gnt_idx[o]]  = PW'(o);
            end
        end

        // move flits along reserved paths
        for (int i = 0; i < NP; i++) begin
            last = 1'b0;
            if (st_q.hold[i] && !fifo_empty[i] &&
                (st_q.cred[st_q.dest[i]] != '0)) begin
                fwd[i]                                          = 1'b1;
                out_valid[st_q.dest[i]]                         = 1'b1;
                out_flit[int'(st_q.dest[i])*FLIT_W +: FLIT_W]   = head[i];
                case (st_q.phase[i])
                    PH_HEAD: begin
                        st_d.phase[i] = PH_SIZE;
                    end
                    PH_SIZE: begin
                        if (head[i][LEN_W-1:0] == '0) begin
                            last = 1'b1;
                        end else begin
                            st_d.remain[i] = head[i][LEN_W-1:0];
                            st_d.phase[i]  = PH_BODY;
                        end
                    end
                    default: begin
                        st_d.remain[i] = st_q.remain[i] - 1'b1;
                        if (st_q.remain[i] == LEN_W'(1)) begin
                            last = 1'b1;
                        end
                    end
                endcase
                if (last) begin
                    st_d.phase[i]            = PH_HEAD;
                    st_d.hold[i]             = 1'b0;
                    st_d.busy[st_q.dest[i]]  = 1'b0;
                end
            end
        end

        // downstream credit bookkeeping
        for (int o = 0; o < NP; o++) begin
            st_d.cred[o] = st_q.cred[o] - CW'(out_valid[o]) + CW'(out_credit[o]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int o = 0; o < NP; o++) begin
                st_q.cred[o] <= CW'(DOWN_DEPTH);
            end
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/router_chk.sv
module router_chk #(
    parameter int NP         = 5,
    parameter int CW         = 4,
    parameter int DOWN_DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NP-1:0]    in_valid,
    input logic [NP-1:0]    in_credit,
    input logic [NP-1:0]    out_valid,
    input logic [NP-1:0]    out_credit,
    input logic [NP-1:0]    fifo_full,
    input logic [NP-1:0]    fifo_empty,
    input logic [NP*CW-1:0] cred_flat
);

    // every forwarded flit appears on exactly one output (R6, R9)
    p_flit_conserve_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_credit) == $countones(out_valid));

    for (genvar g = 0; g < NP; g++) begin : g_port
        // a flit into a full buffer must coincide with a freed slot (R9)
        p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[g] && fifo_full[g]) |-> in_credit[g]);

        // credits go upstream only for flits that were buffered (R9)
        p_credit_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
            in_credit[g] |-> !fifo_empty[g]);

        // no output sends without downstream space (R8)
        p_send_credit_r8: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[g] |-> (cred_flat[g*CW +: CW] != '0));

        // the credit count never exceeds the downstream depth (R8)
        p_credit_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
            cred_flat[g*CW +: CW] <= CW'(DOWN_DEPTH));

        // a spent credit without a return lowers the count by one (R8)
        p_credit_spend_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[g] && !out_credit[g]) |=>
                (cred_flat[g*CW +: CW] == $past(cred_flat[g*CW +: CW]) - 1'b1));
    end

endmodule

bind mesh_router_bp router_chk #(
    .NP         (NP),
    .CW         (CW),
    .DOWN_DEPTH (DOWN_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_credit  (in_credit),
    .out_valid  (out_valid),
    .out_credit (out_credit),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .cred_flat  (cred_flat)
);

// File: tb/mesh_router_bp_tb.sv
module mesh_router_bp_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W   = 32;
    localparam int NP  = 5;
    localparam int MX  = 1;
    localparam int MY  = 1;
    localparam int PP  = 3;
    localparam int DD  = 8;
    localparam int CAP = 512;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [NP-1:0]   in_valid      = '0;
    logic [NP*W-1:0] in_flit       = '0;
    logic [NP-1:0]   in_credit;
    logic [NP-1:0]   out_valid;
    logic [NP*W-1:0] out_flit;
    logic [NP-1:0]   out_credit    = '0;
    logic [NP-1:0]   np_in_credit;
    logic [NP-1:0]   np_out_valid;
    logic [NP*W-1:0] np_out_flit;
    logic [NP-1:0]   np_out_credit = '0;

    mesh_router_bp #(
        .MY_X (MX), .MY_Y (MY), .PERIPH_EN (1'b1), .PERIPH_PORT (PP)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_flit (in_flit), .in_credit (in_credit),
        .out_valid (out_valid), .out_flit (out_flit), .out_credit (out_credit)
    );

    mesh_router_bp #(
        .MY_X (MX), .MY_Y (MY), .PERIPH_EN (1'b0), .PERIPH_PORT (PP)
    ) u_dut_np (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_flit (in_flit), .in_credit (np_in_credit),
        .out_valid (np_out_valid), .out_flit (np_out_flit), .out_credit (np_out_credit)
    );

    logic [W-1:0] tx_buf [NP][CAP];
    int           tx_len [NP] = '{default: 0};
    int           tx_pos [NP];
    int           up_cred[NP];
    logic [W-1:0] rx_buf [NP][CAP];
    int           rx_n   [NP];
    int           pend   [NP];
    int           np_n   [NP];
    int           cr_n   [NP];
    bit           stall  [NP] = '{default: 1'b0};
    int           total = 0, bad = 0, pay_seq = 0;
    bit           finished = 1'b0;

    // single process for link-level driving and observing
    always @(negedge clk) begin
        if (!rst_n) begin
            in_valid = '0;
            for (int p = 0; p < NP; p++) begin
                tx_pos[p] = 0; up_cred[p] = DD; rx_n[p] = 0;
                pend[p] = 0; np_n[p] = 0; cr_n[p] = 0;
            end
        end else begin
            for (int o = 0; o < NP; o++) begin
                if (out_valid[o]) begin
                    if (rx_n[o] < CAP) rx_buf[o][rx_n[o]] = out_flit[o*W +: W];
                    rx_n[o]++;
                    pend[o]++;
                end
                if (!stall[o] && pend[o] > 0) begin
                    out_credit[o] = 1'b1;
                    pend[o]--;
                end else begin
                    out_credit[o] = 1'b0;
                end
                if (np_out_valid[o]) np_n[o]++;
                np_out_credit[o] = np_out_valid[o];
                if (in_credit[o]) begin
                    up_cred[o]++;
                    cr_n[o]++;
                end
                if (tx_pos[o] < tx_len[o] && up_cred[o] > 0) begin
                    in_valid[o]         = 1'b1;
                    in_flit[o*W +: W]   = tx_buf[o][tx_pos[o]];
                    tx_pos[o]++;
                    up_cred[o]--;
                end else begin
                    in_valid[o] = 1'b0;
                end
            end
        end
    end

    task automatic sync();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // header: [3:0]=y, [7:4]=x, [8]=peripheral flag, [26:24]=source tag
    task automatic add_pkt(input int p, input int tx, input int ty, input int fl,
                           input int len, output int start);
        start = tx_len[p];
        tx_buf[p][tx_len[p]]     = 32'((p << 24) | (fl << 8) | (tx << 4) | ty);
        tx_buf[p][tx_len[p] + 1] = 32'(len);
        for (int k = 0; k < len; k++) begin
            pay_seq++;
            tx_buf[p][tx_len[p] + 2 + k] = 32'hC000_0000 | 32'(p << 20) | 32'(pay_seq);
        end
        tx_len[p] = tx_len[p] + 2 + len;
    endtask

    function automatic int exp_port(int tx, int ty, int fl, int pen);
        if (tx > MX) return 0;
        if (tx < MX) return 1;
        if (ty > MY) return 2;
        if (ty < MY) return 3;
        if (fl != 0 && pen != 0) return PP;
        return 4;
    endfunction

    function automatic int mism(int o, int rx_off, int p, int tx_off, int n);
        int m = 0;
        for (int k = 0; k < n; k++) begin
            if (rx_off + k >= CAP || rx_buf[o][rx_off + k] !== tx_buf[p][tx_off + k]) m++;
        end
        return m;
    endfunction

    initial begin
        int base[NP];
        int st, ep, got, sum, nb, m, cb;
        int sw[3], sn[3];

        repeat (3) @(posedge clk);
        sync();
        check(out_valid == '0, "R1 outputs idle in reset", int'(out_valid), 0);
        check(in_credit == '0, "R1 no credit in reset", int'(in_credit), 0);
        rst_n = 1'b1;
        repeat (4) sync();
        check(out_valid == '0, "R1 outputs idle after reset", int'(out_valid), 0);
        check(in_credit == '0, "R1 no credit after reset", int'(in_credit), 0);

        // sweep every target and flag value from the local input
        for (int tx = 0; tx < 4; tx++) begin
            for (int ty = 0; ty < 4; ty++) begin
                for (int fl = 0; fl < 2; fl++) begin
                    string lbl;
                    sync();
                    for (int p = 0; p < NP; p++) base[p] = rx_n[p];
                    nb = np_n[4];
                    add_pkt(4, tx, ty, fl, 1, st);
                    repeat (20) sync();
                    ep  = exp_port(tx, ty, fl, 1);
                    got = rx_n[ep] - base[ep];
                    sum = 0;
                    for (int p = 0; p < NP; p++) sum += rx_n[p] - base[p];
                    m = mism(ep, base[ep], 4, st, 3);
                    if (tx != MX)      lbl = "R2 X first";
                    else if (ty != MY) lbl = "R3 Y second";
                    else if (fl == 0)  lbl = "R4 local delivery";
                    else               lbl = "R5 peripheral port at target";
                    if (fl != 0 && !(tx == MX && ty == MY)) lbl = {lbl, " /R5 flag ignored en route"};
                    check(got == 3 && sum == 3 && m == 0,
                          $sformatf("%s tx=%0d ty=%0d fl=%0d port=%0d", lbl, tx, ty, fl, ep),
                          got * 100 + m, 300);
                    if (tx == MX && ty == MY) begin
                        check(np_n[4] - nb == 3,
                              $sformatf("R11 no-peripheral router local fl=%0d", fl),
                              np_n[4] - nb, 3);
                    end
                end
            end
        end

        // west and north inputs compete for east
        sync();
        for (int p = 0; p < NP; p++) base[p] = rx_n[p];
        for (int k = 0; k < 3; k++) begin
            add_pkt(1, 3, 1, 0, 3, sw[k]);
            add_pkt(2, 3, 1, 0, 3, sn[k]);
        end
        repeat (80) sync();
        got = rx_n[0] - base[0];
        sum = 0;
        for (int p = 1; p < NP; p++) sum += rx_n[p] - base[p];
        check(got == 30 && sum == 0, "R6 all contending flits on east only", got, 30);
        m = 0;
        for (int k = 0; k < 3; k++) begin
            m += mism(0, base[0] + 10 * k,     1, sw[k], 5);
            m += mism(0, base[0] + 10 * k + 5, 2, sn[k], 5);
        end
        check(m == 0, "R7 R6 alternating whole packets", m, 0);

        // zero-length packet must free its output
        sync();
        base[0] = rx_n[0];
        add_pkt(4, 3, 1, 0, 0, st);
        add_pkt(2, 3, 1, 0, 2, sn[0]);
        repeat (40) sync();
        got = rx_n[0] - base[0];
        m = mism(0, base[0], 4, st, 2) + mism(0, base[0] + 2, 2, sn[0], 4);
        check(got == 6 && m == 0, "R10 empty packet releases output", got * 100 + m, 600);

        // stalled downstream on east
        sync();
        stall[0] = 1'b1;
        base[0]  = rx_n[0];
        cb       = cr_n[4];
        add_pkt(4, 3, 1, 0, 12, st);
        repeat (40) sync();
        check(rx_n[0] - base[0] == DD, "R8 sends stop at credit limit", rx_n[0] - base[0], DD);
        check(cr_n[4] - cb == DD, "R9 credits match forwarded flits while stalled",
              cr_n[4] - cb, DD);
        stall[0] = 1'b0;
        repeat (60) sync();
        got = rx_n[0] - base[0];
        m = mism(0, base[0], 4, st, 14);
        check(got == 14 && m == 0, "R8 resumes on returned credits", got * 100 + m, 1400);
        check(cr_n[4] - cb == 14, "R9 one credit per forwarded flit", cr_n[4] - cb, 14);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule